// File: doc/BRIEF.md
# Resolution-Selectable Serial Converter Port

This block is the digital side of a converter that talks to a host over two wires. The host drives a serial clock line. The block drives a single data line back. While asleep, the block holds the data line high and expects the serial clock to rest high. A falling serial-clock edge wakes the block and starts an internal conversion timer.

For a fixed number of system-clock cycles after that start, each further falling edge trades one bit of result width for half the conversion time. The block acknowledges each such edge with a high level on the data line. When the timer expires, the block samples a parallel result from the modulator stub and raises the data line. It then waits until the host shifts the result out, one bit per falling edge, sign bit first.

Reduced results are the most significant bits of the full-width word. After the last bit has been read and the serial clock returns high, the block goes back to sleep. The serial clock is brought into the system clock domain through a flop chain, and edges are detected after that chain.

Top module: `serial_conv_port`

## Requirements
- R1: After reset, and whenever the block is asleep, `sdat_out` is 1.
- R2: A falling edge of `sclk_in` while asleep starts a conversion, and `sdat_out` drops to 0 three system clocks after the edge appears on the input.
- R3: Each falling edge that is recognised within the first `WIN_CYCLES` cycles of a conversion removes one result bit. With k such edges, the conversion lasts `CONV_CYCLES >> k` cycles from the recognised start edge.
- R4: At most `FULL_BITS - MIN_BITS` edges are accepted. Further edges inside the window produce no acknowledge and do not change the length of the conversion or the result width.
- R5: An accepted edge drives `sdat_out` to 1 in the cycle it is recognised. `sdat_out` returns to 0 when `sclk_in` is seen high again, or when the window closes, whichever comes first.
- R6: Falling edges during a conversion but after the window has closed are ignored: no acknowledge, and no change in conversion length.
- R7: When the conversion completes, `conv_data_in` is captured and `sdat_out` goes to 1. It stays 1 until the next falling edge.
- R8: Each falling edge after completion presents the next result bit on `sdat_out`. The first is bit FULL_BITS-1 (the sign), followed by lower bits. Exactly `FULL_BITS - k` bits are presented, which are the top bits of the captured word.
- R9: Once the last bit has been presented, the next rise of `sclk_in` returns the block to sleep (`sdat_out` = 1), and the next falling edge starts a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the host, asynchronous, rests high |
| conv_data_in | input | FULL_BITS | Two's-complement result from the modulator stub |
| sdat_out | output | 1 | Acknowledge, done and serial data line |

## Verification
The bench builds the block with a 16-bit full width, a 10-bit minimum, a 40-cycle window and a 4096-cycle full conversion. With these values the shortest conversion still outlasts the window, and every resolution fits in a few thousand cycles. That short window lets the bench place accepted edges, ignored seventh and eighth edges, a window that closes while the serial clock is held low, and a late edge after the window, all inside one run. Full, 12-bit and 10-bit readouts are each compared against a cycle-level behavioural model.

// File: rtl/scp_pkg.sv
package scp_pkg;

   typedef enum logic [1:0] {
      PH_SLEEP = 2'd0,
      PH_CONV  = 2'd1,
      PH_READY = 2'd2,
      PH_SHIFT = 2'd3
   } phase_t;

endpackage

// File: rtl/scp_edge_sync.sv
module scp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic fall_o,
   output logic rise_o
);

   localparam int TOP = STAGES;

   initial begin : p_param_chk
      assert (STAGES >= 2) else $error("scp_edge_sync: STAGES must be at least 2");
   end

   // chain[0..STAGES-1] synchronise, chain[STAGES] holds previous sample
   logic [TOP:0] chain;

   for (genvar g = 0; g <= TOP; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= line_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign fall_o = chain[TOP] & ~chain[TOP-1];
   assign rise_o = ~chain[TOP] & chain[TOP-1];

endmodule

// File: rtl/scp_conv_timer.sv
module scp_conv_timer #(
   parameter int WIN_CYCLES  = 1000,
   parameter int CONV_CYCLES = 200000,
   parameter int MAX_RED     = 6,
   parameter int CNT_W       = $clog2(CONV_CYCLES + 1),
   parameter int RED_W       = $clog2(MAX_RED + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             active_i,
   input  logic             fall_i,
   input  logic             rise_i,
   output logic [RED_W-1:0] red_o,
   output logic             ack_o,
   output logic             in_win_o,
   output logic             done_o
);

   localparam logic [CNT_W-1:0] WIN_L  = CNT_W'(WIN_CYCLES);
   localparam logic [CNT_W-1:0] FULL_L = CNT_W'(CONV_CYCLES);
   localparam logic [RED_W-1:0] MAX_L  = RED_W'(MAX_RED);

   initial begin : p_param_chk
      assert (WIN_CYCLES > 0) else $error("scp_conv_timer: empty window");
      assert ((CONV_CYCLES >> MAX_RED) > WIN_CYCLES + 1)
         else $error("scp_conv_timer: shortest conversion must outlast the window");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [RED_W-1:0] red_q;
   logic             ack_q;
   logic [CNT_W-1:0] len;
   logic             take;

   assign in_win_o = (cnt_q < WIN_L);
   assign take     = active_i && fall_i && in_win_o && (red_q < MAX_L);
   assign len      = FULL_L >> red_q;
   assign done_o   = active_i && (cnt_q == len - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         red_q <= '0;
         ack_q <= 1'b0;
      end else if (start_i) begin
         cnt_q <= '0;
         red_q <= '0;
         ack_q <= 1'b0;
      end else if (active_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (take) begin
            red_q <= red_q + RED_W'(1);
            ack_q <= 1'b1;
         end else if (rise_i || !in_win_o) begin
            ack_q <= 1'b0;
         end
      end
   end

   assign red_o = red_q;
   assign ack_o = ack_q;

endmodule

// File: rtl/scp_result_shift.sv
module scp_result_shift #(
   parameter int W     = 16,
   parameter int POS_W = $clog2(W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             advance_i,
   input  logic [W-1:0]     word_i,
   input  logic [POS_W-1:0] nbits_i,
   output logic             bit_o,
   output logic             last_o
);

   logic [W-1:0]     sh_q;
   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         pos_q <= '0;
      end else if (load_i) begin
         sh_q  <= word_i;
         pos_q <= '0;
      end else if (advance_i) begin
         // first advance only exposes the top bit, later ones shift
         if (pos_q != '0) sh_q <= {sh_q[W-2:0], 1'b0};
         pos_q <= pos_q + POS_W'(1);
      end
   end

   assign bit_o  = sh_q[W-1];
   assign last_o = (pos_q == nbits_i);

endmodule

// File: rtl/serial_conv_port.sv
module serial_conv_port #(
   parameter int FULL_BITS   = 16,
   parameter int MIN_BITS    = 10,
   parameter int WIN_CYCLES  = 1000,
   parameter int CONV_CYCLES = 200000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk_in,
   input  logic [FULL_BITS-1:0] conv_data_in,
   output logic                 sdat_out
);
   import scp_pkg::*;

   localparam int MAX_RED = FULL_BITS - MIN_BITS;
   localparam int RED_W   = $clog2(MAX_RED + 1);
   localparam int POS_W   = $clog2(FULL_BITS + 1);
   localparam int CNT_W   = $clog2(CONV_CYCLES + 1);

   initial begin : p_param_chk
      assert (MIN_BITS >= 2 && MIN_BITS < FULL_BITS)
         else $error("serial_conv_port: bad width range");
      assert (POS_W > RED_W) else $error("serial_conv_port: width counter too narrow");
   end

   phase_t           ph_q, ph_d;
   logic             fall, rise;
   logic             start, active, done, in_win, ack;
   logic             advance, sh_bit, last;
   logic [RED_W-1:0] red;
   logic [POS_W-1:0] nbits;

   scp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_in(sclk_in),
      .fall_o (fall),
      .rise_o (rise)
   );

   assign start  = (ph_q == PH_SLEEP) && fall;
   assign active = (ph_q == PH_CONV);

   scp_conv_timer #(
      .WIN_CYCLES (WIN_CYCLES),
      .CONV_CYCLES(CONV_CYCLES),
      .MAX_RED    (MAX_RED),
      .CNT_W      (CNT_W),
      .RED_W      (RED_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .active_i(active),
      .fall_i  (fall),
      .rise_i  (rise),
      .red_o   (red),
      .ack_o   (ack),
      .in_win_o(in_win),
      .done_o  (done)
   );

   assign nbits   = POS_W'(FULL_BITS) - POS_W'(red);
   assign advance = ((ph_q == PH_READY) && fall) ||
                    ((ph_q == PH_SHIFT) && fall && !last);

   scp_result_shift #(.W(FULL_BITS), .POS_W(POS_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (done),
      .advance_i(advance),
      .word_i   (conv_data_in),
      .nbits_i  (nbits),
      .bit_o    (sh_bit),
      .last_o   (last)
   );

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_SLEEP: if (fall)         ph_d = PH_CONV;
         PH_CONV:  if (done)         ph_d = PH_READY;
         PH_READY: if (fall)         ph_d = PH_SHIFT;
         PH_SHIFT: if (rise && last) ph_d = PH_SLEEP;
         default:                    ph_d = PH_SLEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_SLEEP;
      else        ph_q <= ph_d;
   end

   always_comb begin
      unique case (ph_q)
         PH_CONV:  sdat_out = ack;
         PH_SHIFT: sdat_out = sh_bit;
         default:  sdat_out = 1'b1;
      endcase
   end

endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
   parameter int MAX_RED = 6,
   parameter int RED_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input scp_pkg::phase_t  ph,
   input logic             fall,
   input logic             rise,
   input logic             in_win,
   input logic             done,
   input logic             ack,
   input logic             last,
   input logic [RED_W-1:0] red,
   input logic             sdat
);
   import scp_pkg::*;

   AST_SLEEP_SDAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_SLEEP) |-> sdat);  // R1

   AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_SLEEP && fall) |=> (ph == PH_CONV && !sdat));  // R2

   AST_RED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_CONV && fall && in_win && red < RED_W'(MAX_RED)) |=> (red == $past(red) + RED_W'(1)) && ack);  // R3

   AST_RED_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_CONV && fall && red == RED_W'(MAX_RED)) |=> (red == RED_W'(MAX_RED)));  // R4

   AST_ACK_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_CONV && !in_win) |=> !ack);  // R5

   AST_ACK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_CONV && rise) |=> !ack);  // R5

   AST_LATE_FALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_CONV && fall && !in_win) |=> $stable(red));  // R6

   AST_DONE_SDAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_CONV && done) |=> (ph == PH_READY && sdat));  // R7

   AST_SHIFT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_SHIFT && last && rise) |=> (ph == PH_SLEEP));  // R9

endmodule

bind serial_conv_port scp_chk #(
   .MAX_RED(MAX_RED),
   .RED_W  (RED_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ph    (ph_q),
   .fall  (fall),
   .rise  (rise),
   .in_win(in_win),
   .done  (done),
   .ack   (ack),
   .last  (last),
   .red   (red),
   .sdat  (sdat_out)
);

// File: tb/serial_conv_port_tb.sv
module serial_conv_port_tb;

   localparam int FB   = 16;
   localparam int MB   = 10;
   localparam int WIN  = 40;
   localparam int CONV = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b1;
   logic [FB-1:0] din = '0;
   logic          sdat;

   always #5 clk = ~clk;

   serial_conv_port #(
      .FULL_BITS(FB), .MIN_BITS(MB), .WIN_CYCLES(WIN),
      .CONV_CYCLES(CONV), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_in(sclk),
      .conv_data_in(din), .sdat_out(sdat)
   );

   int total = 0;
   int bad   = 0;
   int el    = 0;
   int wd    = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit hist[$] = '{1'b1, 1'b1, 1'b1};   // oldest first
   int m_ph   = 0;   // 0 sleep, 1 converting, 2 ready, 3 shifting
   int m_cnt  = 0;
   int m_red  = 0;
   int m_ack  = 0;
   int m_pos  = 0;
   logic [FB-1:0] m_word = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{1'b1, 1'b1, 1'b1};
         m_ph = 0; m_cnt = 0; m_red = 0; m_ack = 0; m_pos = 0;
      end else begin
         bit f, r;
         f = hist[0] && !hist[1];
         r = !hist[0] && hist[1];
         case (m_ph)
            0: if (f) begin m_ph = 1; m_cnt = 0; m_red = 0; m_ack = 0; end
            1: begin
               bit inw;
               inw = (m_cnt < WIN);
               if (m_cnt == (CONV >> m_red) - 1) begin
                  m_ph = 2;
                  m_word = din;
               end
               if (f && inw && m_red < FB - MB) begin
                  m_red++;
                  m_ack = 1;
               end else if (r || !inw) m_ack = 0;
               m_cnt++;
            end
            2: if (f) begin m_ph = 3; m_pos = 1; end
            default: begin
               if (f && m_pos < FB - m_red) m_pos++;
               else if (r && m_pos == FB - m_red) m_ph = 0;
            end
         endcase
         void'(hist.pop_front());
         hist.push_back(sclk);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int exp;
         string tag;
         case (m_ph)
            0: begin exp = 1; tag = "R1 sleep"; end
            1: begin exp = m_ack; tag = "R5 converting"; end
            2: begin exp = 1; tag = "R7 ready"; end
            default: begin exp = int'(m_word[FB - m_pos]); tag = "R8 shifting"; end
         endcase
         chk(sdat == exp[0], tag, int'(sdat), exp);
      end
   end

   // ---------------- watchdog ----------------
   always @(negedge clk) begin
      wd++;
      if (wd > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(input int n);
      repeat (n) @(negedge clk);
      el += n;
   endtask

   task automatic start_conv();
      sclk = 1'b0;
      el = 0;
      step(2);
      sclk = 1'b1;
      step(1);
      chk(sdat == 1'b0, "R2 start", int'(sdat), 0);
      step(1);
   endtask

   task automatic red_pulse(input bit exp_ack, input string req);
      sclk = 1'b0;
      step(3);
      chk(sdat == exp_ack, req, int'(sdat), int'(exp_ack));
      sclk = 1'b1;
      step(2);
   endtask

   task automatic wait_done(input int k);
      int len;
      len = CONV >> k;
      while (el < 3 + len - 1) step(1);
      chk(sdat == 1'b0, "R3 still converting", int'(sdat), 0);
      step(1);
      chk(sdat == 1'b1, "R3 done at expected cycle", int'(sdat), 1);
   endtask

   task automatic read_word(input logic [FB-1:0] w, input int n);
      step(20);
      chk(sdat == 1'b1, "R7 done level held", int'(sdat), 1);
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0;
         step(3);
         chk(sdat == w[FB-1-i], "R8 data bit", int'(sdat), int'(w[FB-1-i]));
         sclk = 1'b1;
         step(3);
      end
      chk(sdat == 1'b1, "R9 back to sleep", int'(sdat), 1);
      step(10);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(sdat == 1'b1, "R1 in reset", int'(sdat), 1);
      rst_n = 1'b1;
      step(6);
      chk(sdat == 1'b1, "R1 after reset", int'(sdat), 1);

      // full 16-bit conversion, no reductions
      din = 16'hA5C3;
      start_conv();
      wait_done(0);
      read_word(16'hA5C3, 16);

      // 12-bit conversion: four accepted reductions
      din = 16'h7FFF;
      start_conv();
      for (int i = 0; i < 4; i++) red_pulse(1'b1, "R3 accepted reduction");
      wait_done(4);
      read_word(16'h7FFF, 12);

      // 10-bit: six accepted, two ignored (R4)
      din = 16'h8040;
      start_conv();
      for (int i = 0; i < 6; i++) red_pulse(1'b1, "R3 accepted reduction");
      for (int i = 0; i < 2; i++) red_pulse(1'b0, "R4 extra edge ignored");
      wait_done(6);
      read_word(16'h8040, 10);

      // one reduction held low across window close, then a late edge
      din = 16'h1234;
      start_conv();
      sclk = 1'b0;
      step(3);
      chk(sdat == 1'b1, "R5 acknowledge", int'(sdat), 1);
      while (el < 43) step(1);
      chk(sdat == 1'b1, "R5 ack before window close", int'(sdat), 1);
      step(1);
      chk(sdat == 1'b0, "R5 ack cleared at window close", int'(sdat), 0);
      step(6);
      sclk = 1'b1;
      step(10);
      sclk = 1'b0;
      step(3);
      chk(sdat == 1'b0, "R6 late edge ignored", int'(sdat), 0);
      sclk = 1'b1;
      step(2);
      wait_done(1);
      read_word(16'h1234, 15);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule